// File: doc/BRIEF.md
# Pin-Change Interrupt Port

An eight-bit general-purpose I/O port that watches its input pads for level changes. The pads pass through a two-flop synchroniser. The synchronised value is compared with the value held from the previous cycle, and every bit that differs is reported on a per-pin event strobe. A whole-port strobe fires alongside them and carries the complete new port value.

A mask register selects which pins may request the single shared interrupt. When a masked-in pin changes, a pending flag is latched and drives the interrupt request line. The flag stays set until the interrupt controller acknowledges it, or until software writes a one to the status register.

Output level, output direction, pin mask and pending status are reached through a simple register bus. It has a write strobe and a three-bit address. Writes take effect at the clock edge and reads are combinational.

Top module: `pcport_top`

## Requirements
- R1: While `rst_n` is low, every register, the synchroniser and the previous-value store are cleared. `pad_out`, `pad_oe`, `pin_evt`, `port_evt` and `irq_req` are all zero.
- R2: With `bus_we` high at a clock edge, address 0 writes the output register, address 1 the direction register and address 3 the mask register. `bus_rdata` returns the register selected by `bus_addr` in the same cycle. `pad_out` follows the output register and `pad_oe` follows the direction register.
- R3: Address 2 reads the synchronised pad sample. A pad level present at edge N is readable after edge N+1. Writes to address 2 have no effect.
- R4: `pin_evt[i]` is high for exactly the one cycle between edges N+1 and N+2 when pad i held a different level at edge N than at edge N-1. It stays low while the pad level is unchanged.
- R5: `port_evt` is high exactly when any `pin_evt` bit is high. `port_val` always carries the synchronised 8-bit value, so bit i is the new level of pin i during its event.
- R6: If `pin_evt & mask` is nonzero before an edge, the pending flag is set after that edge. `irq_req` equals the pending flag, which reads as bit 0 of address 4.
- R7: A pin whose mask bit is zero never sets the pending flag, although its `pin_evt` still fires. With the mask all zero, `irq_req` stays low.
- R8: The pending flag clears at an edge where `irq_ack` is high, or where address 4 is written with bit 0 set. Writing address 4 with bit 0 clear leaves it unchanged.
- R9: If a clear and a new masked event fall on the same edge, the pending flag remains set.
- R10: Addresses 5 to 7 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_in | input | 8 | Asynchronous pad input levels |
| pad_out | output | 8 | Output drive levels |
| pad_oe | output | 8 | Output enable per pin (1 = drive) |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq_ack | input | 1 | Interrupt acknowledge, clears pending |
| irq_req | output | 1 | Shared pin-change interrupt request |
| pin_evt | output | 8 | Per-pin change strobes |
| port_evt | output | 1 | Any-pin change strobe |
| port_val | output | 8 | Synchronised port value (new levels) |

## Verification
The collision that matters is a pending clear, whether from `irq_ack` or from a write of one to address 4, landing on the same edge as a new masked pin change. Clearing must not lose the new event. Directed sequences latch a pending flag and then line up a pad toggle so that its event cycle coincides with the clear. After that edge `irq_req` must still be high. A second clear with no event must then drop it. Random traffic mixes acknowledges, status writes and pad toggles, so these coincidences also occur unplanned and are judged against the bench model.

// File: rtl/pcport_pkg.sv
package pcport_pkg;
    localparam int PW = 8;
    localparam int AW = 3;

    localparam logic [AW-1:0] ADR_OUT  = 3'd0;
    localparam logic [AW-1:0] ADR_DIR  = 3'd1;
    localparam logic [AW-1:0] ADR_SMP  = 3'd2;
    localparam logic [AW-1:0] ADR_MASK = 3'd3;
    localparam logic [AW-1:0] ADR_STAT = 3'd4;

    typedef struct packed {
        logic [PW-1:0] outv;
        logic [PW-1:0] dirv;
        logic [PW-1:0] mask;
        logic          pend;
    } regs_t;

    typedef struct packed {
        logic [PW-1:0] s1;
        logic [PW-1:0] s2;
    } sync_t;
endpackage

// File: rtl/pcport_sync.sv
module pcport_sync
    import pcport_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] pad_i,
    output logic [PW-1:0] smp_o
);
    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pad_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign smp_o = st_q.s2;

    // R3: the sample is the pad value from two edges back
    assert_two_stage_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.s2 == $past(st_q.s1)));
endmodule

// File: rtl/pcport_detect.sv
module pcport_detect
    import pcport_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] smp_i,
    output logic [PW-1:0] evt_o,
    output logic          any_o
);
    logic [PW-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = smp_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    assign evt_o = smp_i ^ prev_q;
    assign any_o = |evt_o;

    // R4: events mark exactly the bits that moved since last cycle
    assert_evt_xor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (evt_o == (smp_i ^ $past(smp_i))));
endmodule

// File: rtl/pcport_regs.sv
module pcport_regs
    import pcport_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [PW-1:0] wdata_i,
    output logic [PW-1:0] rdata_o,
    input  logic [PW-1:0] smp_i,
    input  logic [PW-1:0] evt_i,
    input  logic          ack_i,
    output logic [PW-1:0] out_o,
    output logic [PW-1:0] dir_o,
    output logic          pend_o
);
    regs_t st_d, st_q;
    logic  clr_wr;
    logic  hit;

    always_comb begin
        st_d   = st_q;
        clr_wr = we_i && (addr_i == ADR_STAT) && wdata_i[0];
        hit    = |(evt_i & st_q.mask);
        if (we_i) begin
            case (addr_i)
                ADR_OUT:  st_d.outv = wdata_i;
                ADR_DIR:  st_d.dirv = wdata_i;
                ADR_MASK: st_d.mask = wdata_i;
                default:  ;
            endcase
        end
        // a new masked change outranks any clear in the same cycle
        if (ack_i || clr_wr) st_d.pend = 1'b0;
        if (hit)             st_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (addr_i)
            ADR_OUT:  rdata_o = st_q.outv;
            ADR_DIR:  rdata_o = st_q.dirv;
            ADR_SMP:  rdata_o = smp_i;
            ADR_MASK: rdata_o = st_q.mask;
            ADR_STAT: rdata_o = {{(PW-1){1'b0}}, st_q.pend};
            default:  rdata_o = '0;
        endcase
    end

    assign out_o  = st_q.outv;
    assign dir_o  = st_q.dirv;
    assign pend_o = st_q.pend;

    assert_pend_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_i & st_q.mask)) |=> st_q.pend);
    assert_pend_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.pend && !(|(evt_i & st_q.mask))) |=> !st_q.pend);
    assert_pend_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && !ack_i && !clr_wr) |=> st_q.pend);
    assert_pend_race_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((ack_i || clr_wr) && (|(evt_i & st_q.mask))) |=> st_q.pend);
endmodule

// File: rtl/pcport_top.sv
module pcport_top
    import pcport_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    pad_in,
    output logic [7:0]    pad_out,
    output logic [7:0]    pad_oe,
    input  logic          bus_we,
    input  logic [2:0]    bus_addr,
    input  logic [7:0]    bus_wdata,
    output logic [7:0]    bus_rdata,
    input  logic          irq_ack,
    output logic          irq_req,
    output logic [7:0]    pin_evt,
    output logic          port_evt,
    output logic [7:0]    port_val
);
    logic [PW-1:0] smp;

    pcport_sync u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pad_i (pad_in),
        .smp_o (smp)
    );

    pcport_detect u_detect (
        .clk   (clk),
        .rst_n (rst_n),
        .smp_i (smp),
        .evt_o (pin_evt),
        .any_o (port_evt)
    );

    pcport_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (bus_we),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .rdata_o (bus_rdata),
        .smp_i   (smp),
        .evt_i   (pin_evt),
        .ack_i   (irq_ack),
        .out_o   (pad_out),
        .dir_o   (pad_oe),
        .pend_o  (irq_req)
    );

    assign port_val = smp;

    assert_port_evt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        port_evt |-> (port_val != $past(port_val)));
endmodule

// File: tb/pcport_top_bench.sv
module pcport_top_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_out, pad_oe, bus_rdata, pin_evt, port_val;
    logic       bus_we = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       irq_ack = 1'b0;
    logic       irq_req, port_evt;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    // bench model state
    logic [7:0] m_s1, m_s2, m_prev, m_out, m_dir, m_mask;
    logic       m_pend;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcport_top u_pcport_top (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_ack(irq_ack),
        .irq_req(irq_req), .pin_evt(pin_evt), .port_evt(port_evt),
        .port_val(port_val)
    );

    function automatic logic [7:0] exp_rdata(input logic [2:0] a);
        case (a)
            3'd0: return m_out;
            3'd1: return m_dir;
            3'd2: return m_s2;
            3'd3: return m_mask;
            3'd4: return {7'd0, m_pend};
            default: return 8'd0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic check_all();
        chk("R2 pad_out", pad_out, m_out);
        chk("R2 pad_oe", pad_oe, m_dir);
        chk("R2/R3/R10 rdata", bus_rdata, exp_rdata(bus_addr));
        chk("R4 pin_evt", pin_evt, m_s2 ^ m_prev);
        chk("R5 port_evt", {7'd0, port_evt}, {7'd0, |(m_s2 ^ m_prev)});
        chk("R5 port_val", port_val, m_s2);
        chk("R6 irq_req", {7'd0, irq_req}, {7'd0, m_pend});
    endtask

    task automatic step(input logic [7:0] pad, input logic we, input logic [2:0] a,
                        input logic [7:0] wd, input logic ack);
        logic [7:0] evt;
        logic       clr;
        pad_in = pad; bus_we = we; bus_addr = a; bus_wdata = wd; irq_ack = ack;
        @(posedge clk);
        evt = m_s2 ^ m_prev;
        clr = ack || (we && a == 3'd4 && wd[0]);
        m_pend = (m_pend && !clr) || (|(evt & m_mask));
        if (we && a == 3'd0) m_out = wd;
        if (we && a == 3'd1) m_dir = wd;
        if (we && a == 3'd3) m_mask = wd;
        m_prev = m_s2; m_s2 = m_s1; m_s1 = pad;
        @(negedge clk);
        check_all();
    endtask

    initial begin
        int seed;
        logic [7:0] p;
        seed = $urandom(32'd20240611);
        m_s1 = 0; m_s2 = 0; m_prev = 0; m_out = 0; m_dir = 0; m_mask = 0; m_pend = 0;
        pad_in = 8'hA5;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 pad_out", pad_out, 8'h00);
        chk("R1 pad_oe", pad_oe, 8'h00);
        chk("R1 pin_evt", pin_evt, 8'h00);
        chk("R1 irq_req", {7'd0, irq_req}, 8'h00);
        pad_in = 8'h00;
        rst_n = 1'b1;

        // R2 register writes, R10 unmapped addresses, R3 write to sample ignored
        step(8'h00, 1, 3'd0, 8'h3C, 0);
        step(8'h00, 1, 3'd1, 8'hF0, 0);
        step(8'h00, 1, 3'd5, 8'hFF, 0);
        step(8'h00, 1, 3'd2, 8'h77, 0);
        for (int a = 0; a < 8; a++) step(8'h00, 0, 3'(a), 8'h00, 0);

        // R7: mask zero, pins toggle, no interrupt
        step(8'h81, 0, 3'd4, 0, 0);
        for (int i = 0; i < 4; i++) step(8'h00, 0, 3'd2, 0, 0);
        chk("R7 mask zero no irq", {7'd0, irq_req}, 8'h00);

        // R6: unmask pin 0, toggle, pending sets
        step(8'h00, 1, 3'd3, 8'h01, 0);
        step(8'h01, 0, 3'd4, 0, 0);
        for (int i = 0; i < 3; i++) step(8'h01, 0, 3'd4, 0, 0);
        chk("R6 masked change pends", {7'd0, irq_req}, 8'h01);
        // R8: write zero no effect, write one clears
        step(8'h01, 1, 3'd4, 8'h00, 0);
        chk("R8 w0 keeps", {7'd0, irq_req}, 8'h01);
        step(8'h01, 1, 3'd4, 8'h01, 0);
        chk("R8 w1 clears", {7'd0, irq_req}, 8'h00);

        // R9: pad toggle at edge N -> event between N+1 and N+2, clear at N+2
        step(8'h01, 1, 3'd4, 8'h00, 0);
        step(8'h00, 0, 3'd4, 0, 0);  // edge N
        step(8'h00, 0, 3'd4, 0, 0);  // edge N+1: event now visible
        chk("R9 event present", pin_evt, 8'h01);
        step(8'h00, 0, 3'd4, 0, 0);  // edge N+2: pending set
        step(8'h01, 0, 3'd4, 0, 0);  // toggle again
        step(8'h01, 0, 3'd4, 0, 0);
        step(8'h01, 0, 3'd4, 0, 1);  // ack coincides with masked event
        chk("R9 ack race keeps pend", {7'd0, irq_req}, 8'h01);
        step(8'h01, 0, 3'd4, 0, 1);
        chk("R8 ack clears", {7'd0, irq_req}, 8'h00);

        // random phase
        p = 8'h01;
        for (int i = 0; i < 3000; i++) begin
            logic [2:0] a;
            if (($urandom % 3) == 0) p = p ^ 8'($urandom);
            a = 3'($urandom);
            step(p, ($urandom % 4) == 0, a, 8'($urandom), ($urandom % 8) == 0);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule